// File: doc/BRIEF.md
# Fetch/Execute Cycle Sequencer

This block is the per-cycle control engine of a small 8-bit processor. Every clock it performs at most one memory action on a single-port byte interface: it fetches an opcode at the program counter, advances the program counter in the decode step, hands the execute step to an external instruction unit, reads an operand byte at the program counter, or loads or stores a byte at an index address. It owns the program counter, the index register and the byte latch that carries every value read or written.

The state codes are sparse. With no request, the low two bits of the state step by one and the upper bits clear, so the machine loops fetch, decode, stall and execute. During the execute step the instruction unit may redirect the next state to an operand read or to a two-step index load or store setup, and may load the index register and the latch. Each of those paths ends back in the stall state and then execute, so a multi-byte instruction is a chain of such requests.

A free-running cycle counter runs beside the sequencer and drives an event strobe that is high whenever the count is at or above a threshold register.

Top module: `cpu_step_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the next state is FETCH (code 0) and the program counter, index register, byte latch, cycle counter and event threshold all become 0.
- R2: State codes are FETCH=0, DECODE=1, STALL=2, EXEC=3, LOAD=5, STORE=9, IDX_LD=10, IDX_ST=11, OPND=12, OPND_WAIT=13. With no redirect the next state is {2'b00, state[1:0]+1}, giving FETCH, DECODE, STALL, EXEC, FETCH.
- R3: In FETCH, mem_rd is 1 with mem_addr equal to the program counter and the read byte is captured in the latch; in DECODE the program counter increases by one.
- R4: exec_req is acted on only in EXEC: 0 means no redirect, 1 selects OPND, 2 selects IDX_LD, 3 selects IDX_ST. In any other state exec_req has no effect on the next state.
- R5: In OPND the block reads at the program counter into the latch and increments the program counter; OPND is followed by OPND_WAIT and then STALL.
- R6: IDX_LD is followed by LOAD, where mem_rd is 1 with mem_addr equal to the index register and the byte is captured in the latch; LOAD is followed by STALL.
- R7: IDX_ST is followed by STORE, where mem_wr is 1, mem_addr equals the index register and mem_wdata equals the latch; STORE is followed by STALL.
- R8: exec_idx_we loads exec_idx into the index register and exec_bus_we loads exec_bus into the latch, only in EXEC; outside EXEC both strobes are ignored.
- R9: After reset the cycle counter increases by one every clock; thr_we loads thr_val into the threshold at the next edge; event_o is 1 exactly when the counter is at or above the threshold.
- R10: mem_wr is high only in STORE, mem_rd only in FETCH, OPND and LOAD, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read this cycle |
| mem_wr | output | 1 | Memory write this cycle |
| mem_wdata | output | 8 | Write byte (the latch) |
| mem_rdata | input | 8 | Read byte, valid in the same cycle as the address |
| exec_req | input | 2 | Next-state redirect from the instruction unit |
| exec_idx_we | input | 1 | Load index register (EXEC only) |
| exec_idx | input | 16 | New index value |
| exec_bus_we | input | 1 | Load latch (EXEC only) |
| exec_bus | input | 8 | New latch value |
| thr_we | input | 1 | Load event threshold |
| thr_val | input | 16 | New threshold value |
| state_o | output | 4 | Current state code |
| pc_o | output | 16 | Program counter |
| idx_o | output | 16 | Index register |
| bus_o | output | 8 | Byte latch (opcode during DECODE) |
| cycle_o | output | 16 | Cycle counter |
| event_o | output | 1 | Counter at or above threshold |

## Verification
The sequencer is driven through a chain of execute-step requests covering no redirect, operand reads, index loads with and without an index update, and index stores of both a freshly loaded latch value and a latch left over from an operand read; the state trail of each tells apart the wrap-around increment from the explicit setup steps. A store followed by a load from the same index address separates a correct write path from one that drops or misroutes data. Requests and load strobes applied outside the execute step show whether the block wrongly acts on them, and a reset taken in the middle of an operand read plus a threshold crossing set a few cycles ahead show the counter and event edge landing on the exact cycle.

// File: rtl/seq_pkg.sv
// Shared types for the fetch/execute sequencer.
// Assumes: state codes are fixed because the default next-state rule
// relies on the low two bits of each code.
package seq_pkg;

    typedef enum logic [3:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_STALL     = 4'd2,
        ST_EXEC      = 4'd3,
        ST_LOAD      = 4'd5,
        ST_STORE     = 4'd9,
        ST_IDX_LD    = 4'd10,
        ST_IDX_ST    = 4'd11,
        ST_OPND      = 4'd12,
        ST_OPND_WAIT = 4'd13
    } seq_state_e;

    typedef enum logic [1:0] {
        RQ_NONE  = 2'd0,
        RQ_OPND  = 2'd1,
        RQ_LOAD  = 2'd2,
        RQ_STORE = 2'd3
    } exec_req_e;

endpackage

// File: rtl/seq_state_ctl.sv
// Next-state engine of the sequencer.
// Does: holds the current state; steps the low two state bits by default,
// takes redirects from the instruction unit in EXEC, and routes the setup
// states to their access states.
// Assumes: exec_req is only meaningful during EXEC.
module seq_state_ctl
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] exec_req,
    output seq_state_e state_q
);

    seq_state_e state_d;

    // Purpose: choose the following state from the current one.
    always_comb begin
        state_d = seq_state_e'({2'b00, state_q[1:0] + 2'd1});
        case (state_q)
            ST_EXEC: begin
                case (exec_req)
                    RQ_OPND:  state_d = ST_OPND;
                    RQ_LOAD:  state_d = ST_IDX_LD;
                    RQ_STORE: state_d = ST_IDX_ST;
                    default:  state_d = ST_FETCH;
                endcase
            end
            ST_OPND:   state_d = ST_OPND_WAIT;
            ST_IDX_LD: state_d = ST_LOAD;
            ST_IDX_ST: state_d = ST_STORE;
            default:   ;
        endcase
    end

    // Purpose: state register with synchronous reset to FETCH.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/seq_datapath.sv
// Address and data side of the sequencer.
// Does: owns program counter, index register and byte latch; drives the
// single-port memory interface according to the current state.
// Assumes: mem_rdata is valid in the same cycle the address is presented.
module seq_datapath
    import seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              exec_idx_we,
    input  logic [ADDR_W-1:0] exec_idx,
    input  logic              exec_bus_we,
    input  logic [DATA_W-1:0] exec_bus,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] idx_q,
    output logic [DATA_W-1:0] bus_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic in_exec;
    logic pc_adv;
    logic capture;

    assign in_exec = (state == ST_EXEC);
    assign pc_adv  = (state == ST_DECODE) || (state == ST_OPND);
    assign capture = (state == ST_FETCH) || (state == ST_OPND) || (state == ST_LOAD);

    // Purpose: pick the memory address and strobes for this state.
    always_comb begin
        mem_addr  = pc_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = bus_q;
        case (state)
            ST_FETCH, ST_OPND: mem_rd = 1'b1;
            ST_LOAD: begin
                mem_addr = idx_q;
                mem_rd   = 1'b1;
            end
            ST_STORE: begin
                mem_addr = idx_q;
                mem_wr   = 1'b1;
            end
            default: ;
        endcase
    end

    // Purpose: program counter, advanced in DECODE and OPND.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (pc_adv) pc_q <= pc_q + PC_STEP;
    end

    // Purpose: index register, written only by the instruction unit in EXEC.
    always_ff @(posedge clk) begin
        if (!rst_n)                      idx_q <= '0;
        else if (in_exec && exec_idx_we) idx_q <= exec_idx;
    end

    // Purpose: byte latch, filled by reads or by the instruction unit in EXEC.
    always_ff @(posedge clk) begin
        if (!rst_n)                      bus_q <= '0;
        else if (capture)                bus_q <= mem_rdata;
        else if (in_exec && exec_bus_we) bus_q <= exec_bus;
    end

endmodule

// File: rtl/seq_event_ctr.sv
// Cycle counter with programmable event threshold.
// Does: counts every clock after reset (wrapping at full scale) and flags
// when the count is at or above the threshold register.
// Assumes: threshold writes take effect at the next edge.
module seq_event_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             event_o
);

    localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(1);

    logic [CNT_W-1:0] thr_q;

    // Purpose: free-running cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_STEP;
    end

    // Purpose: threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= '0;
        else if (thr_we) thr_q <= thr_val;
    end

    assign event_o = (cnt_q >= thr_q);

endmodule

// File: rtl/cpu_step_seq.sv
// Top of the fetch/execute sequencer.
// Does: joins the state engine, datapath and event counter; exposes the
// memory port, the instruction-unit request port and observation outputs.
// Assumes: one memory action per clock, combinational read data.
module cpu_step_seq
    import seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [1:0]        exec_req,
    input  logic              exec_idx_we,
    input  logic [ADDR_W-1:0] exec_idx,
    input  logic              exec_bus_we,
    input  logic [DATA_W-1:0] exec_bus,
    input  logic              thr_we,
    input  logic [CNT_W-1:0]  thr_val,
    output logic [3:0]        state_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic [DATA_W-1:0] bus_o,
    output logic [CNT_W-1:0]  cycle_o,
    output logic              event_o
);

    seq_state_e state_q;

    seq_state_ctl u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_req (exec_req),
        .state_q  (state_q)
    );

    seq_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state_q),
        .mem_rdata   (mem_rdata),
        .exec_idx_we (exec_idx_we),
        .exec_idx    (exec_idx),
        .exec_bus_we (exec_bus_we),
        .exec_bus    (exec_bus),
        .pc_q        (pc_o),
        .idx_q       (idx_o),
        .bus_q       (bus_o),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_wdata   (mem_wdata)
    );

    seq_event_ctr #(
        .CNT_W (CNT_W)
    ) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .thr_we  (thr_we),
        .thr_val (thr_val),
        .cnt_q   (cycle_o),
        .event_o (event_o)
    );

    assign state_o = state_q;

endmodule

// File: rtl/cpu_step_seq_chk.sv
// Property checker for the sequencer, attached by bind below.
// Does: watches the top-level ports for state-trail, strobe and counter
// rules. Assumes: synchronous active-low reset.
module cpu_step_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        state_o,
    input logic [1:0]        exec_req,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] idx_o,
    input logic [CNT_W-1:0]  cycle_o,
    input logic              mem_rd,
    input logic              mem_wr
);

    AST_WR_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> state_o == 4'd9); // R10
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R10
    AST_EXEC_IDLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (state_o == 4'd3 && exec_req == 2'd0) |=> state_o == 4'd0); // R2
    AST_EXEC_OPND: assert property (@(posedge clk) disable iff (!rst_n) (state_o == 4'd3 && exec_req == 2'd1) |=> state_o == 4'd12); // R4
    AST_OPND_NEXT: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd12 |=> state_o == 4'd13); // R5
    AST_IDXLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd10 |=> state_o == 4'd5); // R6
    AST_IDXST_NEXT: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd11 |=> state_o == 4'd9); // R7
    AST_PC_DECODE: assert property (@(posedge clk) disable iff (!rst_n) state_o == 4'd1 |=> pc_o == ADDR_W'($past(pc_o) + 1)); // R3
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) state_o != 4'd3 |=> $stable(idx_o)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> cycle_o == CNT_W'($past(cycle_o) + 1)); // R9

endmodule

bind cpu_step_seq cpu_step_seq_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_o  (state_o),
    .exec_req (exec_req),
    .pc_o     (pc_o),
    .idx_o    (idx_o),
    .cycle_o  (cycle_o),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr)
);

// File: tb/cpu_step_seq_bench.sv
// Bench for the sequencer: a vector table of execute-step requests walked
// by one loop, then directed tests for ignored strobes, the event
// threshold and a reset taken mid-operation.
module cpu_step_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    typedef struct packed {
        logic [1:0]  req;
        logic        idx_we;
        logic [15:0] idx;
        logic        bus_we;
        logic [7:0]  bval;
        logic [3:0]  s1;
        logic [3:0]  s2;
        logic [3:0]  s3;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 1'b0, 16'h0000, 1'b0, 8'h00, 4'd0,  4'd1,  4'd2},
        '{2'd1, 1'b0, 16'h0000, 1'b0, 8'h00, 4'd12, 4'd13, 4'd2},
        '{2'd2, 1'b1, 16'h0040, 1'b0, 8'h00, 4'd10, 4'd5,  4'd2},
        '{2'd3, 1'b1, 16'h0041, 1'b1, 8'hA5, 4'd11, 4'd9,  4'd2},
        '{2'd2, 1'b1, 16'h0041, 1'b0, 8'h00, 4'd10, 4'd5,  4'd2},
        '{2'd1, 1'b0, 16'h0000, 1'b0, 8'h00, 4'd12, 4'd13, 4'd2},
        '{2'd3, 1'b1, 16'h1234, 1'b0, 8'h00, 4'd11, 4'd9,  4'd2},
        '{2'd0, 1'b0, 16'h0000, 1'b0, 8'h00, 4'd0,  4'd1,  4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [1:0]  exec_req = 2'd0;
    logic        exec_idx_we = 1'b0;
    logic [15:0] exec_idx = '0;
    logic        exec_bus_we = 1'b0;
    logic [7:0]  exec_bus = '0;
    logic        thr_we = 1'b0;
    logic [15:0] thr_val = '0;
    logic [3:0]  state_o;
    logic [15:0] pc_o, idx_o, cycle_o;
    logic [7:0]  bus_o;
    logic        event_o;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench memory: contents computed at reset, written by the store port.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
        end else if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end
    assign mem_rdata = mem[mem_addr[7:0]];

    cpu_step_seq u_cpu_step_seq (
        .clk (clk), .rst_n (rst_n),
        .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_wr (mem_wr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .exec_req (exec_req), .exec_idx_we (exec_idx_we), .exec_idx (exec_idx),
        .exec_bus_we (exec_bus_we), .exec_bus (exec_bus),
        .thr_we (thr_we), .thr_val (thr_val),
        .state_o (state_o), .pc_o (pc_o), .idx_o (idx_o), .bus_o (bus_o),
        .cycle_o (cycle_o), .event_o (event_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] exp_pc;
        logic [15:0] exp_idx;
        logic [7:0]  exp_bus;
        logic [15:0] c0;

        repeat (3) tick();
        // R1: values after reset edges
        chk("R1 state", 32'(state_o), 32'd0);
        chk("R1 pc", 32'(pc_o), 32'd0);
        chk("R1 idx", 32'(idx_o), 32'd0);
        chk("R1 bus", 32'(bus_o), 32'd0);
        chk("R1 cycle", 32'(cycle_o), 32'd0);
        rst_n = 1'b1;

        // R3: fetch of the first opcode
        chk("R3 fetch rd", 32'(mem_rd), 32'd1);
        chk("R3 fetch addr", 32'(mem_addr), 32'd0);
        tick();
        chk("R2 decode", 32'(state_o), 32'd1);
        chk("R3 opcode latch", 32'(bus_o), 32'(mem[0]));
        exp_bus = mem[0];
        tick();
        chk("R2 stall", 32'(state_o), 32'd2);
        chk("R3 pc step", 32'(pc_o), 32'd1);
        tick();
        chk("R2 exec", 32'(state_o), 32'd3);
        chk("R9 count", 32'(cycle_o), 32'd3);
        exp_pc = 16'd1;
        exp_idx = 16'd0;

        // Table walk: one execute-step request per entry.
        for (int v = 0; v < NVEC; v++) begin
            exec_req    = TBL[v].req;
            exec_idx_we = TBL[v].idx_we;
            exec_idx    = TBL[v].idx;
            exec_bus_we = TBL[v].bus_we;
            exec_bus    = TBL[v].bval;
            tick();
            exec_req = 2'd0; exec_idx_we = 1'b0; exec_bus_we = 1'b0;
            if (TBL[v].idx_we) exp_idx = TBL[v].idx;
            if (TBL[v].bus_we) exp_bus = TBL[v].bval;
            chk("R4 redirect", 32'(state_o), 32'(TBL[v].s1));
            chk("R8 idx load", 32'(idx_o), 32'(exp_idx));
            if (TBL[v].req == 2'd0 || TBL[v].req == 2'd1) begin
                chk("R5 rd at pc", 32'({mem_rd, mem_addr}), 32'({1'b1, exp_pc}));
                exp_bus = mem[exp_pc[7:0]];
                if (TBL[v].req == 2'd1) exp_pc = exp_pc + 16'd1;
            end
            tick();
            chk("R5 second step", 32'(state_o), 32'(TBL[v].s2));
            case (TBL[v].req)
                2'd0: begin
                    chk("R3 latch", 32'(bus_o), 32'(exp_bus));
                    exp_pc = exp_pc + 16'd1;
                end
                2'd1: begin
                    chk("R5 operand latch", 32'(bus_o), 32'(exp_bus));
                    chk("R5 pc step", 32'(pc_o), 32'(exp_pc));
                end
                2'd2: begin
                    chk("R6 load strobe", 32'({mem_rd, mem_wr, mem_addr}), 32'({2'b10, exp_idx}));
                    exp_bus = mem[exp_idx[7:0]];
                end
                default: begin
                    chk("R7 store strobe", 32'({mem_rd, mem_wr, mem_addr}), 32'({2'b01, exp_idx}));
                    chk("R7 store data", 32'(mem_wdata), 32'(exp_bus));
                end
            endcase
            tick();
            chk("R2 back to stall", 32'(state_o), 32'(TBL[v].s3));
            chk("R6 latch", 32'(bus_o), 32'(exp_bus));
            chk("R3 pc", 32'(pc_o), 32'(exp_pc));
            if (TBL[v].req == 2'd3) chk("R7 memory written", 32'(mem[exp_idx[7:0]]), 32'(exp_bus));
            tick();
            chk("R2 exec again", 32'(state_o), 32'd3);
        end

        // R4/R8: request and load strobes outside EXEC have no effect.
        tick();
        chk("R2 wrap to fetch", 32'(state_o), 32'd0);
        exec_req = 2'd1; exec_idx_we = 1'b1; exec_idx = 16'hBEEF;
        exec_bus_we = 1'b1; exec_bus = 8'h77;
        exp_bus = mem[exp_pc[7:0]];
        tick();
        exec_req = 2'd0; exec_idx_we = 1'b0; exec_bus_we = 1'b0;
        chk("R4 ignored req", 32'(state_o), 32'd1);
        chk("R8 ignored idx", 32'(idx_o), 32'(exp_idx));
        chk("R8 ignored bus", 32'(bus_o), 32'(exp_bus));
        chk("R10 no strobes", 32'({mem_rd, mem_wr}), 32'd0);

        // R9: threshold set four cycles ahead.
        c0 = cycle_o;
        thr_we = 1'b1; thr_val = c0 + 16'd4;
        tick();
        thr_we = 1'b0;
        chk("R9 below thr", 32'(event_o), 32'd0);
        chk("R9 count step", 32'(cycle_o), 32'(c0 + 16'd1));
        tick(); tick();
        chk("R9 still below", 32'(event_o), 32'd0);
        tick();
        chk("R9 at thr", 32'(event_o), 32'd1);
        chk("R9 count", 32'(cycle_o), 32'(c0 + 16'd4));
        thr_we = 1'b1; thr_val = 16'h8000;
        tick();
        thr_we = 1'b0;
        chk("R9 high thr", 32'(event_o), 32'd0);

        // R1: reset taken in the middle of an operand read.
        for (int k = 0; k < 8 && state_o != 4'd3; k++) tick();
        exec_req = 2'd1;
        tick();
        exec_req = 2'd0;
        chk("R5 opnd", 32'(state_o), 32'd12);
        rst_n = 1'b0;
        tick();
        chk("R1 state mid", 32'(state_o), 32'd0);
        chk("R1 pc mid", 32'(pc_o), 32'd0);
        chk("R1 idx mid", 32'(idx_o), 32'd0);
        chk("R1 bus mid", 32'(bus_o), 32'd0);
        chk("R1 cycle mid", 32'(cycle_o), 32'd0);
        chk("R1 thr cleared", 32'(event_o), 32'd1);
        rst_n = 1'b1;
        tick();
        chk("R2 restart", 32'(state_o), 32'd1);

        summary();
        $finish;
    end

endmodule